// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit resolves control flow for one instruction per cycle. It takes the current program counter, two register operands, the immediate fields of the instruction (a 16-bit word offset and a 26-bit jump field), a destination register number and a decoded control-flow kind. From these it works out three things: whether the flow is redirected, the address the fetch stage should use next, and whether a return address must be written back, to which register and with which value.

Six conditional branches are supported. Two of them compare the two operands with each other. Four of them compare the first operand, read as a signed number, against zero. Relative targets are counted from the instruction that follows the branch. Absolute jumps keep the top four bits of that following address. Register jumps take the first operand as the new address.

All results are registered, so they appear one clock after the inputs are presented. A pipeline stage consumes the results directly. Instruction fetch, hazards, squashing the slot after a branch, and exceptions are handled elsewhere.

Top module: `npc_unit`

## Requirements
- R1: While reset is high at a clock edge, every output is zero after that edge.
- R2: Kind 1 (equal branch) sets taken_o when opa_i equals opb_i. Kind 2 (not-equal branch) sets taken_o when the two operands differ.
- R3: Kinds 3, 4, 5 and 6 read opa_i as a signed value and set taken_o when it is, respectively, >= 0, > 0, <= 0 and < 0.
- R4: For a taken conditional branch, target_o is pc_i + 4 + (sign-extended imm16_i << 2), with wraparound modulo 2^32. For a branch that is not taken, target_o is pc_i + 4.
- R5: Kinds 7 (jump) and 8 (jump and link) always set taken_o. Their target_o is {(pc_i+4)[31:28], tgt26_i, 2'b00}.
- R6: Kinds 9 (register jump) and 10 (register jump and link) always set taken_o, with target_o equal to opa_i.
- R7: Kind 8 sets link_we_o, with link_idx_o = 31. Kind 10 sets link_we_o, with link_idx_o = dest_i. In both cases link_data_o = pc_i + 8.
- R8: Kind 0, any kind from 11 to 15, and every kind that does not link give link_we_o = 0, link_idx_o = 0 and link_data_o = 0. Kind 0 and kinds 11 to 15 also give taken_o = 0 and target_o = pc_i + 4.
- R9: Each output reflects the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm16_i | input | 16 | Signed word offset for relative branches |
| tgt26_i | input | 26 | Word index for absolute jumps |
| dest_i | input | 5 | Link destination for register jump and link |
| kind_i | input | 4 | Control-flow kind code (see R2 to R8) |
| taken_o | output | 1 | Flow is redirected |
| target_o | output | 32 | Next fetch address |
| link_we_o | output | 1 | Return address write enable |
| link_idx_o | output | 5 | Return address register number |
| link_data_o | output | 32 | Return address value |

## Verification
The unit holds no state beyond its output register. A wrong decision therefore shows on taken_o and target_o in the cycle right after the faulty inputs, and never later. An error in the compare logic appears only for operand values on the sign or zero boundary, so the sweep crosses every kind with values at zero, one, minus one and both extremes of the signed range. Errors in address arithmetic or field placement show up as a wrong target_o. They become visible once the offset is negative or the program counter sits at the top of the address space, where the addition wraps and the region bits change.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN      = 32;
    localparam int OFFW      = 16;
    localparam int JFW       = 26;
    localparam int RIDXW     = 5;
    localparam int KINDW     = 4;
    localparam int INSN_B    = 4;
    localparam int REGIONW   = XLEN - JFW - 2;
    localparam logic [RIDXW-1:0] RA_IDX = RIDXW'(31);

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [RIDXW-1:0] ridx_t;

    typedef enum logic [KINDW-1:0] {
        CF_NONE = 4'd0,
        CF_BEQ  = 4'd1,
        CF_BNE  = 4'd2,
        CF_BGEZ = 4'd3,
        CF_BGTZ = 4'd4,
        CF_BLEZ = 4'd5,
        CF_BLTZ = 4'd6,
        CF_J    = 4'd7,
        CF_JAL  = 4'd8,
        CF_JR   = 4'd9,
        CF_JALR = 4'd10
    } cf_kind_e;

    typedef enum logic [1:0] {
        TGT_SEQ,
        TGT_REL,
        TGT_REGION,
        TGT_REG
    } tgt_sel_e;

    typedef struct packed {
        logic  taken;
        word_t target;
        logic  link_we;
        ridx_t link_idx;
        word_t link_data;
    } npc_res_t;

    function automatic word_t rel_disp(input logic [OFFW-1:0] off);
        word_t ext;
        ext = {{(XLEN-OFFW){off[OFFW-1]}}, off};
        return ext << 2;
    endfunction

    function automatic word_t region_addr(input word_t seq, input logic [JFW-1:0] fld);
        return {seq[XLEN-1 -: REGIONW], fld, 2'b00};
    endfunction

    function automatic logic is_cond(input cf_kind_e k);
        return (k == CF_BEQ) || (k == CF_BNE) || (k == CF_BGEZ) ||
               (k == CF_BGTZ) || (k == CF_BLEZ) || (k == CF_BLTZ);
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  cf_kind_e kind,
    input  word_t    opa,
    input  word_t    opb,
    output logic     redirect,
    output tgt_sel_e sel
);
    logic ops_eq;
    logic a_neg;
    logic a_zero;
    logic cond_hit;

    assign ops_eq = (opa == opb);
    assign a_neg  = opa[XLEN-1];
    assign a_zero = (opa == '0);

    always_comb begin
        unique case (kind)
            CF_BEQ:  cond_hit = ops_eq;
            CF_BNE:  cond_hit = !ops_eq;
            CF_BGEZ: cond_hit = !a_neg;
            CF_BGTZ: cond_hit = !a_neg && !a_zero;
            CF_BLEZ: cond_hit = a_neg || a_zero;
            CF_BLTZ: cond_hit = a_neg;
            default: cond_hit = 1'b0;
        endcase
    end

    always_comb begin
        redirect = 1'b0;
        sel      = TGT_SEQ;
        if (is_cond(kind)) begin
            redirect = cond_hit;
            sel      = cond_hit ? TGT_REL : TGT_SEQ;
        end else begin
            case (kind)
                CF_J, CF_JAL: begin
                    redirect = 1'b1;
                    sel      = TGT_REGION;
                end
                CF_JR, CF_JALR: begin
                    redirect = 1'b1;
                    sel      = TGT_REG;
                end
                default: begin
                    redirect = 1'b0;
                    sel      = TGT_SEQ;
                end
            endcase
        end
    end
endmodule

// File: rtl/npc_addr.sv
module npc_addr
    import npc_pkg::*;
(
    input  word_t            pc,
    input  word_t            opa,
    input  logic [OFFW-1:0]  off,
    input  logic [JFW-1:0]   jfield,
    input  tgt_sel_e         sel,
    output word_t            seq_pc,
    output word_t            target
);
    word_t rel_pc;
    word_t reg_pc;

    assign seq_pc = pc + word_t'(INSN_B);
    assign rel_pc = seq_pc + rel_disp(off);
    assign reg_pc = region_addr(seq_pc, jfield);

    always_comb begin
        unique case (sel)
            TGT_REL:    target = rel_pc;
            TGT_REGION: target = reg_pc;
            TGT_REG:    target = opa;
            default:    target = seq_pc;
        endcase
    end
endmodule

// File: rtl/npc_link.sv
module npc_link
    import npc_pkg::*;
(
    input  cf_kind_e kind,
    input  word_t    seq_pc,
    input  ridx_t    dest,
    output logic     we,
    output ridx_t    idx,
    output word_t    data
);
    always_comb begin
        we   = 1'b0;
        idx  = '0;
        data = '0;
        case (kind)
            CF_JAL: begin
                we   = 1'b1;
                idx  = RA_IDX;
                data = seq_pc + word_t'(INSN_B);
            end
            CF_JALR: begin
                we   = 1'b1;
                idx  = dest;
                data = seq_pc + word_t'(INSN_B);
            end
            default: begin
                we   = 1'b0;
                idx  = '0;
                data = '0;
            end
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] pc_i,
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic [15:0] imm16_i,
    input  logic [25:0] tgt26_i,
    input  logic [4:0]  dest_i,
    input  logic [3:0]  kind_i,
    output logic        taken_o,
    output logic [31:0] target_o,
    output logic        link_we_o,
    output logic [4:0]  link_idx_o,
    output logic [31:0] link_data_o
);
    cf_kind_e kind;
    logic     redirect;
    tgt_sel_e sel;
    word_t    seq_pc;
    word_t    nxt_target;
    logic     l_we;
    ridx_t    l_idx;
    word_t    l_data;
    npc_res_t res_d;
    npc_res_t res_q;

    assign kind = cf_kind_e'(kind_i);

    npc_cond u_cond (
        .kind     (kind),
        .opa      (opa_i),
        .opb      (opb_i),
        .redirect (redirect),
        .sel      (sel)
    );

    npc_addr u_addr (
        .pc     (pc_i),
        .opa    (opa_i),
        .off    (imm16_i),
        .jfield (tgt26_i),
        .sel    (sel),
        .seq_pc (seq_pc),
        .target (nxt_target)
    );

    npc_link u_link (
        .kind   (kind),
        .seq_pc (seq_pc),
        .dest   (dest_i),
        .we     (l_we),
        .idx    (l_idx),
        .data   (l_data)
    );

    always_comb begin
        res_d.taken     = redirect;
        res_d.target    = nxt_target;
        res_d.link_we   = l_we;
        res_d.link_idx  = l_idx;
        res_d.link_data = l_data;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign taken_o     = res_q.taken;
    assign target_o    = res_q.target;
    assign link_we_o   = res_q.link_we;
    assign link_idx_o  = res_q.link_idx;
    assign link_data_o = res_q.link_data;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_i,
    input logic [31:0] opa_i,
    input logic [3:0]  kind_i,
    input logic        taken_o,
    input logic [31:0] target_o,
    input logic        link_we_o,
    input logic [4:0]  link_idx_o,
    input logic [31:0] link_data_o
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!taken_o && !link_we_o && target_o == 32'd0 && link_data_o == 32'd0));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ($past(kind_i) == 4'd0 || $past(kind_i) > 4'd10)) |-> (!taken_o && !link_we_o));

    a_r4_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !taken_o) |-> (target_o == $past(pc_i) + 32'd4));

    a_r6_reg_target: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ($past(kind_i) == 4'd9 || $past(kind_i) == 4'd10)) |-> (taken_o && target_o == $past(opa_i)));

    a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
        (past_ok && link_we_o) |-> (link_data_o == $past(pc_i) + 32'd8));

    a_r7_ra_index: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(kind_i) == 4'd8) |-> (link_we_o && link_idx_o == 5'd31));

    a_r8_no_link_zero: assert property (@(posedge clk) disable iff (rst)
        !link_we_o |-> (link_idx_o == 5'd0 && link_data_o == 32'd0));
endmodule

bind npc_unit npc_unit_chk i_npc_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_i        (pc_i),
    .opa_i       (opa_i),
    .kind_i      (kind_i),
    .taken_o     (taken_o),
    .target_o    (target_o),
    .link_we_o   (link_we_o),
    .link_idx_o  (link_idx_o),
    .link_data_o (link_data_o)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0, opa_i = '0, opb_i = '0;
    logic [15:0] imm16_i = '0;
    logic [25:0] tgt26_i = '0;
    logic [4:0]  dest_i = '0;
    logic [3:0]  kind_i = '0;
    logic        taken_o, link_we_o;
    logic [31:0] target_o, link_data_o;
    logic [4:0]  link_idx_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst(rst), .pc_i(pc_i), .opa_i(opa_i), .opb_i(opb_i),
        .imm16_i(imm16_i), .tgt26_i(tgt26_i), .dest_i(dest_i), .kind_i(kind_i),
        .taken_o(taken_o), .target_o(target_o), .link_we_o(link_we_o),
        .link_idx_o(link_idx_o), .link_data_o(link_data_o)
    );

    localparam logic [31:0] VALS [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                        32'h8000_0000, 32'h5, 32'hFFFF_FFFB, 32'h1234_5678};
    localparam logic [31:0] PCS  [3] = '{32'h0040_0100, 32'hFFFF_FFFC, 32'h2FFF_FFF8};
    localparam logic [15:0] IMMS [3] = '{16'h0003, 16'h8001, 16'hFFFF};

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s kind=%0d actual=%h expected=%h", tag, what, kind_i, act, exp);
        end
    endtask

    function automatic string tag_of(input int k);
        case (k)
            1, 2:       return "R2";
            3, 4, 5, 6: return "R3";
            7, 8:       return "R5";
            9, 10:      return "R6";
            default:    return "R8";
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset clears everything, even with busy inputs
        kind_i = 4'd8; pc_i = 32'h1000; opa_i = 32'h55;
        repeat (3) @(negedge clk);
        chk("R1", "taken", {31'd0, taken_o}, 32'd0);
        chk("R1", "target", target_o, 32'd0);
        chk("R1", "link_we", {31'd0, link_we_o}, 32'd0);
        chk("R1", "link_idx", {27'd0, link_idx_o}, 32'd0);
        chk("R1", "link_data", link_data_o, 32'd0);
        rst = 1'b0;

        for (int k = 0; k < 16; k++) begin
            for (int p = 0; p < 3; p++) begin
                for (int a = 0; a < 8; a++) begin
                    for (int b = 0; b < 8; b++) begin
                        logic        e_tk, e_we;
                        logic [31:0] e_tg, e_ld, seq, sa;
                        logic [4:0]  e_ix;
                        string       t;
                        kind_i  = 4'(k);
                        pc_i    = PCS[p];
                        opa_i   = VALS[a];
                        opb_i   = VALS[b];
                        imm16_i = IMMS[(a + b) % 3];
                        tgt26_i = 26'h2AB_CDEF ^ 26'(b * 26'h01F_0F37);
                        dest_i  = 5'(a * 5 + b);
                        seq = pc_i + 32'd4;
                        sa  = opa_i;
                        e_we = 1'b0; e_ix = '0; e_ld = '0;
                        case (k)
                            1: e_tk = (opa_i == opb_i);
                            2: e_tk = (opa_i != opb_i);
                            3: e_tk = ($signed(sa) >= 0);
                            4: e_tk = ($signed(sa) > 0);
                            5: e_tk = ($signed(sa) <= 0);
                            6: e_tk = ($signed(sa) < 0);
                            7, 8, 9, 10: e_tk = 1'b1;
                            default: e_tk = 1'b0;
                        endcase
                        if (k >= 1 && k <= 6)
                            e_tg = e_tk ? seq + ($signed({{16{imm16_i[15]}}, imm16_i}) * 4) : seq;
                        else if (k == 7 || k == 8)
                            e_tg = (seq & 32'hF000_0000) | ({6'd0, tgt26_i} * 4);
                        else if (k == 9 || k == 10)
                            e_tg = opa_i;
                        else
                            e_tg = seq;
                        if (k == 8)  begin e_we = 1'b1; e_ix = 5'd31;  e_ld = pc_i + 32'd8; end
                        if (k == 10) begin e_we = 1'b1; e_ix = dest_i; e_ld = pc_i + 32'd8; end
                        t = tag_of(k);
                        @(negedge clk);
                        // R9: one edge later the outputs reflect these inputs
                        chk(t, "taken", {31'd0, taken_o}, {31'd0, e_tk});
                        chk((k >= 1 && k <= 6) ? "R4" : t, "target", target_o, e_tg);
                        chk((k == 8 || k == 10) ? "R7" : "R8", "link_we", {31'd0, link_we_o}, {31'd0, e_we});
                        chk((k == 8 || k == 10) ? "R7" : "R8", "link_idx", {27'd0, link_idx_o}, {27'd0, e_ix});
                        chk((k == 8 || k == 10) ? "R7" : "R8", "link_data", link_data_o, e_ld);
                    end
                end
            end
        end

        // R9: outputs hold one cycle after inputs change, then follow
        kind_i = 4'd9; opa_i = 32'hAAAA_0000;
        @(negedge clk);
        kind_i = 4'd0; pc_i = 32'h100;
        #2;
        chk("R9", "target_hold", target_o, 32'hAAAA_0000);
        @(negedge clk);
        chk("R9", "target_next", target_o, 32'h104);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule